// File: doc/BRIEF.md
# Parallel Display Bus Window-Update Master

This block is the bus-side engine for an external display controller that sits behind an asynchronous parallel command/data bus. The bus has a chip select, a write strobe, a read strobe and a command/data select. When a frame update is requested, the block opens the controller's window register and writes an 18-byte window record over an 8-bit path. It then switches the bus to 16 bits and writes one RGB565 pixel per access. Pixels come from a valid/ready stream until the whole frame has been sent, and a one-cycle `done` pulse closes the update.

The block also performs a single-register read: one command byte carries the register address, then one read access follows, and the sampled bus value is returned with a one-cycle `rd_valid` pulse. Every access has a fixed length in time. The strobe edges are given in picoseconds and converted to clock ticks by rounding up against the clock period parameter. Only a full-frame update is legal. Any other window raises `err` for one cycle and produces no bus activity.

Top module: `pdb_master`

## Requirements
- R1: After reset and whenever no transaction is in progress, the bus is idle: `bus_cs_n`, `bus_we_n` and `bus_re_n` are high, `bus_d_oe` is low and `busy` is low.
- R2: Every access holds `bus_cs_n` low for ceil(36 ns / clock period) cycles, which is 8 at 200 MHz. On a write access, `bus_we_n` is low from tick ceil(9 ns/T) to tick ceil(18 ns/T) exclusive, which is ticks 2 and 3 at 200 MHz, counting from tick 0, the first cycle with chip select low. The two strobes are never low together, and `bus_cs_n` returns high for at least one cycle between accesses.
- R3: On a read access, `bus_re_n` is low from tick ceil(9 ns/T) to tick ceil(27 ns/T) exclusive, which is ticks 2 to 5. `bus_d_oe` stays low, and `bus_d_in` is captured at the clock edge that ends tick ceil(27 ns/T), which is tick 6.
- R4: An accepted update starts with a command access (`bus_dc` = 0) carrying byte 0x6C. Eighteen data accesses (`bus_dc` = 1) follow. All of these are 8-bit: `bus_wide` = 0 and bits 15:8 of `bus_d_out` are zero.
- R5: Record bytes 0 to 7 are x, y, x+w-1 and y+h-1, each written low byte first. Bytes 8 to 15 repeat bytes 0 to 7. Byte 16 is 0x01, the RGB565 format code.
- R6: Record byte 17 is 0x00 when `variant` is 1 or 2, and 0x01 for every other variant value.
- R7: After the record, the block performs exactly FRAME_W×FRAME_H write accesses with `bus_wide` = 1 and `bus_dc` = 1. Each access carries one pixel taken on a cycle where `pix_valid` and `pix_ready` are both high, in stream order. `pix_ready` is never high without `pix_valid`, and the block waits while `pix_valid` is low.
- R8: An update whose window is not x=0, y=0, w=FRAME_W, h=FRAME_H produces a one-cycle `err` pulse and no access.
- R9: `done` pulses for one cycle, together with `busy` falling, right after the last pixel access ends. It never pulses outside that point.
- R10: A read request makes a command access carrying `rd_addr`, then one read access. After that, `rd_valid` pulses once with `rd_data` equal to the captured 16-bit bus value.
- R11: Requests that arrive while `busy` is high are ignored. When `upd_req` and `rd_req` arrive in the same idle cycle, only the update is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_req | input | 1 | Frame update request (one cycle) |
| win_x | input | 16 | Window start column |
| win_y | input | 16 | Window start row |
| win_w | input | 16 | Window width |
| win_h | input | 16 | Window height |
| variant | input | 8 | Controller variant code |
| rd_req | input | 1 | Register read request (one cycle) |
| rd_addr | input | 8 | Register address for the read |
| pix_data | input | 16 | RGB565 pixel |
| pix_valid | input | 1 | Pixel available |
| pix_ready | output | 1 | Pixel taken this cycle |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_re_n | output | 1 | Read strobe, active low |
| bus_dc | output | 1 | 0 = command byte, 1 = data |
| bus_wide | output | 1 | 1 = 16 data lines in use, 0 = 8 |
| bus_d_oe | output | 1 | Data output enable |
| bus_d_out | output | 16 | Data driven toward the bus |
| bus_d_in | input | 16 | Data read from the bus |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Frame update finished (pulse) |
| err | output | 1 | Update window rejected (pulse) |
| rd_valid | output | 1 | Read data valid (pulse) |
| rd_data | output | 16 | Value sampled during the read access |

## Verification
The two functions that can collide are the frame update and the register read, because both start from the same idle cycle. The bench raises `upd_req` and `rd_req` on the same edge. It then checks the logged access sequence: the first access must be the 0x6C command, the count must be exactly 19 plus the pixel count, no read strobe may appear and `rd_valid` must never pulse. A second collision is provoked by pulsing both requests in the middle of the pixel stream, and the access log and the count of `done` pulses must not change.

// File: rtl/pdb_pkg.sv
// Package: shared types and helpers for the parallel display bus master.
// Assumes timing parameters are given in picoseconds.
package pdb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WCMD = 3'd1,
        ST_WREC = 3'd2,
        ST_PIX  = 3'd3,
        ST_RCMD = 3'd4,
        ST_RDAT = 3'd5
    } pdb_state_e;

    localparam logic [7:0] FMT_RGB565   = 8'h01;
    localparam logic [7:0] SRC_PLAIN    = 8'h00;
    localparam logic [7:0] SRC_FALLBACK = 8'h01;
    localparam int         REC_LEN      = 18;

    // Round a time up to whole clock ticks.
    function automatic int ceil_ticks(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/pdb_access_timer.sv
// Access timer: runs one bus access of CYC_T ticks. It places the write or
// read strobe at fixed tick offsets and captures read data at tick SMP_T.
// Assumes start is only raised while busy_o is low, and that
// WE_ON_T < WE_OFF_T <= CYC_T and RE_ON_T < RE_OFF_T <= CYC_T with SMP_T < CYC_T.
module pdb_access_timer #(
    parameter int CYC_T    = 8,
    parameter int WE_ON_T  = 2,
    parameter int WE_OFF_T = 4,
    parameter int RE_ON_T  = 2,
    parameter int RE_OFF_T = 6,
    parameter int SMP_T    = 6,
    parameter int DW       = 16,
    parameter int NW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rd_mode,
    input  logic          wide_i,
    input  logic          dc_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] din,
    output logic          busy_o,
    output logic          last_o,
    output logic          cs_n,
    output logic          we_n,
    output logic          re_n,
    output logic          dc_o,
    output logic          wide_o,
    output logic          oe_o,
    output logic [DW-1:0] dout_o,
    output logic [DW-1:0] rdata_o
);
    localparam int CW = $clog2(CYC_T + 1);

    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          rd_q;
    logic          wide_q;
    logic          dc_q;
    logic [DW-1:0] dout_q;
    logic [DW-1:0] rdata_q;

    // Access sequencing: latch the access on start, then count the ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            rd_q     <= 1'b0;
            wide_q   <= 1'b0;
            dc_q     <= 1'b1;
            dout_q   <= '0;
        end else if (!active_q) begin
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                rd_q     <= rd_mode;
                wide_q   <= wide_i;
                dc_q     <= dc_i;
                dout_q   <= wide_i ? wdata_i : {{(DW-NW){1'b0}}, wdata_i[NW-1:0]};
            end
        end else if (cnt_q == CW'(CYC_T - 1)) begin
            active_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // Read capture at the sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (active_q && rd_q && cnt_q == CW'(SMP_T)) begin
            rdata_q <= din;
        end
    end

    assign busy_o  = active_q;
    assign last_o  = active_q && (cnt_q == CW'(CYC_T - 1));
    assign cs_n    = !active_q;
    assign we_n    = !(active_q && !rd_q && cnt_q >= CW'(WE_ON_T) && cnt_q < CW'(WE_OFF_T));
    assign re_n    = !(active_q &&  rd_q && cnt_q >= CW'(RE_ON_T) && cnt_q < CW'(RE_OFF_T));
    assign dc_o    = active_q ? dc_q : 1'b1;
    assign wide_o  = active_q && wide_q;
    assign oe_o    = active_q && !rd_q;
    assign dout_o  = (active_q && !rd_q) ? dout_q : '0;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/pdb_win_record.sv
// Window record generator: returns byte idx of the 18-byte window record.
// Coordinates go low byte first and the 8-byte block is sent twice.
// Assumes idx < 18. Purely combinational.
module pdb_win_record #(
    parameter int CRD_W = 16
) (
    input  logic [CRD_W-1:0] x,
    input  logic [CRD_W-1:0] y,
    input  logic [CRD_W-1:0] w,
    input  logic [CRD_W-1:0] h,
    input  logic [7:0]       variant,
    input  logic [4:0]       idx,
    output logic [7:0]       rec_byte
);
    import pdb_pkg::*;

    logic [CRD_W-1:0] word_sel;
    logic [CRD_W-1:0] x_end;
    logic [CRD_W-1:0] y_end;
    logic [7:0]       src_code;

    assign x_end    = x + w - CRD_W'(1);
    assign y_end    = y + h - CRD_W'(1);
    assign src_code = (variant == 8'd1 || variant == 8'd2) ? SRC_PLAIN : SRC_FALLBACK;

    // Pick the coordinate word for the current byte.
    always_comb begin
        case (idx[2:1])
            2'd0:    word_sel = x;
            2'd1:    word_sel = y;
            2'd2:    word_sel = x_end;
            default: word_sel = y_end;
        endcase
    end

    // Map the byte index to a coordinate byte or a trailing code.
    always_comb begin
        if (idx == 5'd16)      rec_byte = FMT_RGB565;
        else if (idx == 5'd17) rec_byte = src_code;
        else                   rec_byte = idx[0] ? word_sel[15:8] : word_sel[7:0];
    end

endmodule

// File: rtl/pdb_region_chk.sv
// Region check: accepts only a window that covers the whole frame.
// Purely combinational.
module pdb_region_chk #(
    parameter int FRAME_W = 800,
    parameter int FRAME_H = 480,
    parameter int CRD_W   = 16
) (
    input  logic [CRD_W-1:0] x,
    input  logic [CRD_W-1:0] y,
    input  logic [CRD_W-1:0] w,
    input  logic [CRD_W-1:0] h,
    output logic             ok
);
    assign ok = (x == '0) && (y == '0) &&
                (w == CRD_W'(FRAME_W)) && (h == CRD_W'(FRAME_H));
endmodule

// File: rtl/pdb_master.sv
// Parallel display bus master: performs a full-frame window update
// (command, 18-byte record over 8 lines, pixels over 16 lines) and
// single-register reads. Assumes requests are single-cycle pulses and a
// frame of at least two pixels. Edge offsets are converted from
// picoseconds to ticks by rounding up.
module pdb_master #(
    parameter int         CLK_PS     = 5000,
    parameter int         ACC_PS     = 36000,
    parameter int         WE_ON_PS   = 9000,
    parameter int         WE_OFF_PS  = 18000,
    parameter int         RE_ON_PS   = 9000,
    parameter int         RE_OFF_PS  = 27000,
    parameter int         SMP_PS     = 27000,
    parameter int         FRAME_W    = 800,
    parameter int         FRAME_H    = 480,
    parameter int         CRD_W      = 16,
    parameter logic [7:0] WIN_REG    = 8'h6C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_req,
    input  logic [CRD_W-1:0] win_x,
    input  logic [CRD_W-1:0] win_y,
    input  logic [CRD_W-1:0] win_w,
    input  logic [CRD_W-1:0] win_h,
    input  logic [7:0]       variant,
    input  logic             rd_req,
    input  logic [7:0]       rd_addr,
    input  logic [15:0]      pix_data,
    input  logic             pix_valid,
    output logic             pix_ready,
    output logic             bus_cs_n,
    output logic             bus_we_n,
    output logic             bus_re_n,
    output logic             bus_dc,
    output logic             bus_wide,
    output logic             bus_d_oe,
    output logic [15:0]      bus_d_out,
    input  logic [15:0]      bus_d_in,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             rd_valid,
    output logic [15:0]      rd_data
);
    import pdb_pkg::*;

    localparam int CYC_T    = ceil_ticks(ACC_PS, CLK_PS);
    localparam int WE_ON_T  = ceil_ticks(WE_ON_PS, CLK_PS);
    localparam int WE_OFF_T = ceil_ticks(WE_OFF_PS, CLK_PS);
    localparam int RE_ON_T  = ceil_ticks(RE_ON_PS, CLK_PS);
    localparam int RE_OFF_T = ceil_ticks(RE_OFF_PS, CLK_PS);
    localparam int SMP_T    = ceil_ticks(SMP_PS, CLK_PS);
    localparam int NPIX     = FRAME_W * FRAME_H;
    localparam int PCW      = (NPIX > 1) ? $clog2(NPIX) : 1;

    pdb_state_e       state_q;
    logic [4:0]       idx_q;
    logic [PCW-1:0]   pcnt_q;
    logic [CRD_W-1:0] x_q, y_q, w_q, h_q;
    logic [7:0]       var_q;
    logic [7:0]       raddr_q;
    logic             done_q, err_q, rdv_q;
    logic [15:0]      rdat_q;

    logic             region_ok;
    logic [7:0]       rec_byte;
    logic             a_start, a_rd, a_wide, a_dc;
    logic [15:0]      a_data;
    logic             t_busy, t_last;
    logic [15:0]      t_rdata;

    pdb_region_chk #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .CRD_W(CRD_W)) u_region (
        .x(win_x), .y(win_y), .w(win_w), .h(win_h), .ok(region_ok)
    );

    pdb_win_record #(.CRD_W(CRD_W)) u_record (
        .x(x_q), .y(y_q), .w(w_q), .h(h_q), .variant(var_q),
        .idx(idx_q), .rec_byte(rec_byte)
    );

    pdb_access_timer #(
        .CYC_T(CYC_T), .WE_ON_T(WE_ON_T), .WE_OFF_T(WE_OFF_T),
        .RE_ON_T(RE_ON_T), .RE_OFF_T(RE_OFF_T), .SMP_T(SMP_T),
        .DW(16), .NW(8)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(a_start), .rd_mode(a_rd),
        .wide_i(a_wide), .dc_i(a_dc), .wdata_i(a_data), .din(bus_d_in),
        .busy_o(t_busy), .last_o(t_last), .cs_n(bus_cs_n), .we_n(bus_we_n),
        .re_n(bus_re_n), .dc_o(bus_dc), .wide_o(bus_wide), .oe_o(bus_d_oe),
        .dout_o(bus_d_out), .rdata_o(t_rdata)
    );

    // Access request decode: what to put on the bus next, per state.
    always_comb begin
        a_start   = 1'b0;
        a_rd      = 1'b0;
        a_wide    = 1'b0;
        a_dc      = 1'b1;
        a_data    = '0;
        pix_ready = 1'b0;
        case (state_q)
            ST_WCMD: begin
                a_start = !t_busy;
                a_dc    = 1'b0;
                a_data  = {8'h00, WIN_REG};
            end
            ST_WREC: begin
                a_start = !t_busy;
                a_data  = {8'h00, rec_byte};
            end
            ST_PIX: begin
                a_start   = !t_busy && pix_valid;
                pix_ready = a_start;
                a_wide    = 1'b1;
                a_data    = pix_data;
            end
            ST_RCMD: begin
                a_start = !t_busy;
                a_dc    = 1'b0;
                a_data  = {8'h00, raddr_q};
            end
            ST_RDAT: begin
                a_start = !t_busy;
                a_rd    = 1'b1;
            end
            default: ;
        endcase
    end

    // Transaction sequencer: accept requests and step through the accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pcnt_q  <= '0;
            x_q     <= '0;
            y_q     <= '0;
            w_q     <= '0;
            h_q     <= '0;
            var_q   <= '0;
            raddr_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdv_q   <= 1'b0;
            rdat_q  <= '0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            rdv_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (upd_req) begin
                        if (region_ok) begin
                            x_q     <= win_x;
                            y_q     <= win_y;
                            w_q     <= win_w;
                            h_q     <= win_h;
                            var_q   <= variant;
                            state_q <= ST_WCMD;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end else if (rd_req) begin
                        raddr_q <= rd_addr;
                        state_q <= ST_RCMD;
                    end
                end
                ST_WCMD: begin
                    if (t_last) begin
                        idx_q   <= '0;
                        state_q <= ST_WREC;
                    end
                end
                ST_WREC: begin
                    if (t_last) begin
                        if (idx_q == 5'(REC_LEN - 1)) begin
                            pcnt_q  <= '0;
                            state_q <= ST_PIX;
                        end else begin
                            idx_q <= idx_q + 5'd1;
                        end
                    end
                end
                ST_PIX: begin
                    if (t_last) begin
                        if (pcnt_q == PCW'(NPIX - 1)) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            pcnt_q <= pcnt_q + PCW'(1);
                        end
                    end
                end
                ST_RCMD: begin
                    if (t_last) state_q <= ST_RDAT;
                end
                ST_RDAT: begin
                    if (t_last) begin
                        rdat_q  <= t_rdata;
                        rdv_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign rd_valid = rdv_q;
    assign rd_data  = rdat_q;

endmodule

// File: rtl/pdb_master_chk.sv
// Checker: bus-level properties of pdb_master, attached with bind.
// Observes top-level ports only.
module pdb_master_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_cs_n,
    input logic bus_we_n,
    input logic bus_re_n,
    input logic bus_dc,
    input logic bus_wide,
    input logic bus_d_oe,
    input logic busy,
    input logic done,
    input logic err,
    input logic pix_valid,
    input logic pix_ready,
    input logic rd_valid
);
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_cs_n && bus_we_n && bus_re_n && !bus_d_oe));

    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_we_n && !bus_re_n));

    p_strobe_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we_n || !bus_re_n) |-> !bus_cs_n);

    p_read_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re_n |-> !bus_d_oe);

    p_cmd_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !bus_dc) |-> !bus_wide);

    p_ready_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> pix_valid);

    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && bus_cs_n));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && bus_cs_n));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!busy && !done));

endmodule

bind pdb_master pdb_master_chk u_pdb_master_chk (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
    .bus_re_n(bus_re_n), .bus_dc(bus_dc), .bus_wide(bus_wide),
    .bus_d_oe(bus_d_oe), .busy(busy), .done(done), .err(err),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .rd_valid(rd_valid)
);

// File: tb/tb_pdb_master.sv
`timescale 1ns/1ps
module tb_pdb_master;
    localparam int CLK_PS   = 5000;
    localparam int FW       = 4;
    localparam int FH       = 2;
    localparam int NPIX     = FW * FH;
    localparam int CYC_T    = (36000 + CLK_PS - 1) / CLK_PS;
    localparam int WE_ON_T  = (9000  + CLK_PS - 1) / CLK_PS;
    localparam int WE_OFF_T = (18000 + CLK_PS - 1) / CLK_PS;
    localparam int RE_ON_T  = (9000  + CLK_PS - 1) / CLK_PS;
    localparam int RE_OFF_T = (27000 + CLK_PS - 1) / CLK_PS;
    localparam int SMP_T    = (27000 + CLK_PS - 1) / CLK_PS;
    localparam logic [15:0] RD_GOOD = 16'h335A;
    localparam logic [15:0] RD_JUNK = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_req = 1'b0;
    logic [15:0] win_x = '0, win_y = '0, win_w = '0, win_h = '0;
    logic [7:0]  variant = '0;
    logic        rd_req = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] pix_data = '0;
    logic        pix_valid = 1'b0;
    logic        pix_ready;
    logic        bus_cs_n, bus_we_n, bus_re_n, bus_dc, bus_wide, bus_d_oe;
    logic [15:0] bus_d_out;
    logic [15:0] bus_d_in = RD_JUNK;
    logic        busy, done, err, rd_valid;
    logic [15:0] rd_data;

    pdb_master #(.CLK_PS(CLK_PS), .FRAME_W(FW), .FRAME_H(FH)) dut (
        .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .win_x(win_x), .win_y(win_y),
        .win_w(win_w), .win_h(win_h), .variant(variant), .rd_req(rd_req),
        .rd_addr(rd_addr), .pix_data(pix_data), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
        .bus_re_n(bus_re_n), .bus_dc(bus_dc), .bus_wide(bus_wide),
        .bus_d_oe(bus_d_oe), .bus_d_out(bus_d_out), .bus_d_in(bus_d_in),
        .busy(busy), .done(done), .err(err), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Access log filled by the bus monitor.
    int          acc_n = 0;
    int          acc_len [64];
    bit          acc_bad [64];
    bit          acc_dc  [64];
    bit          acc_w   [64];
    bit          acc_oe  [64];
    logic [15:0] acc_d   [64];
    int          k = 0;
    bit          cur_dc, cur_w, cur_oe, cur_bad;
    logic [15:0] cur_d;
    int          done_n = 0, err_n = 0, rdv_n = 0;
    bit          pix_on = 0;
    bit          pix_gap = 0;
    int          pidx = 0;
    int          cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pix_val(input int i);
        return 16'hC300 ^ 16'(i * 16'h0111);
    endfunction

    // Bus monitor: tracks tick position, checks strobes, drives read data.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!bus_cs_n) begin
                if (k == 0) begin
                    cur_dc = bus_dc; cur_w = bus_wide; cur_oe = bus_d_oe;
                    cur_d = bus_d_out; cur_bad = 0;
                end
                if (bus_we_n != !(cur_oe && k >= WE_ON_T && k < WE_OFF_T)) cur_bad = 1;
                if (bus_re_n != !(!cur_oe && k >= RE_ON_T && k < RE_OFF_T)) cur_bad = 1;
                if (bus_d_oe != cur_oe || bus_d_out != cur_d || bus_dc != cur_dc) cur_bad = 1;
                bus_d_in = (k == SMP_T) ? RD_GOOD : RD_JUNK;
                k++;
            end else if (k != 0) begin
                if (acc_n < 64) begin
                    acc_len[acc_n] = k; acc_bad[acc_n] = cur_bad; acc_dc[acc_n] = cur_dc;
                    acc_w[acc_n] = cur_w; acc_oe[acc_n] = cur_oe; acc_d[acc_n] = cur_d;
                end
                acc_n++;
                k = 0;
                bus_d_in = RD_JUNK;
            end
            if (done) done_n++;
            if (err) err_n++;
            if (rd_valid) rdv_n++;
        end
    end

    // Pixel source: optional stall pattern, index advances on handshake.
    always @(negedge clk) begin
        pix_valid = pix_on && !(pix_gap && (cyc % 3 == 0));
        pix_data  = pix_val(pidx);
        #1;
        if (pix_valid && pix_ready) pidx++;
    end

    // Watchdog: a hung run becomes a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            chk(0, "WD", "watchdog expired", cyc, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle_check(input string tag);
        chk(bus_cs_n && bus_we_n && bus_re_n && !bus_d_oe && !busy, "R1",
            {"idle bus ", tag}, {bus_cs_n, bus_we_n, bus_re_n, bus_d_oe, busy}, 5'b11100);
    endtask

    task automatic chk_acc(input int i, input bit dc, input bit w, input bit oe,
                           input logic [15:0] d, input string req);
        chk(acc_len[i] == CYC_T && !acc_bad[i], "R2", $sformatf("timing acc %0d", i),
            acc_len[i], CYC_T);
        chk(acc_dc[i] == dc && acc_w[i] == w && acc_oe[i] == oe && (!oe || acc_d[i] == d),
            req, $sformatf("acc %0d dc/wide/oe/data", i),
            {acc_dc[i], acc_w[i], acc_oe[i], acc_d[i]}, {dc, w, oe, d});
    endtask

    task automatic pulse_upd(input int x, input int y, input int w, input int h,
                             input logic [7:0] v, input bit with_rd);
        @(negedge clk);
        win_x = 16'(x); win_y = 16'(y); win_w = 16'(w); win_h = 16'(h); variant = v;
        upd_req = 1; rd_req = with_rd; rd_addr = 8'h02;
        @(negedge clk);
        upd_req = 0; rd_req = 0;
    endtask

    task automatic run_update(input logic [7:0] v, input bit gap, input bit collide);
        int d0;
        logic [7:0] src;
        logic [7:0] rec [18];
        acc_n = 0; pidx = 0; d0 = done_n; pix_gap = gap; pix_on = 1;
        pulse_upd(0, 0, FW, FH, v, collide);
        while (done_n == d0) begin
            @(negedge clk);
            if (collide && acc_n == 21 && k == 1) begin
                upd_req = 1; rd_req = 1;
                @(negedge clk);
                upd_req = 0; rd_req = 0;
            end
        end
        pix_on = 0;
        repeat (CYC_T + 4) @(negedge clk);
        src = (v == 8'd1 || v == 8'd2) ? 8'h00 : 8'h01;
        for (int j = 0; j < 2; j++) begin
            rec[j*8+0] = 8'h00; rec[j*8+1] = 8'h00; rec[j*8+2] = 8'h00; rec[j*8+3] = 8'h00;
            rec[j*8+4] = 8'(FW - 1); rec[j*8+5] = 8'((FW - 1) >> 8);
            rec[j*8+6] = 8'(FH - 1); rec[j*8+7] = 8'((FH - 1) >> 8);
        end
        rec[16] = 8'h01; rec[17] = src;
        chk(acc_n == 19 + NPIX, collide ? "R11" : "R7", "access count", acc_n, 19 + NPIX);
        chk(done_n == d0 + 1, "R9", "single done pulse", done_n - d0, 1);
        chk_acc(0, 0, 0, 1, 16'h006C, "R4");
        for (int i = 0; i < 18; i++)
            chk_acc(1 + i, 1, 0, 1, {8'h00, rec[i]}, (i == 17) ? "R6" : "R5");
        for (int i = 0; i < NPIX; i++)
            chk_acc(19 + i, 1, 1, 1, pix_val(i), "R7");
        chk(pidx == NPIX, "R7", "pixels handed over", pidx, NPIX);
        idle_check("after update");
    endtask

    initial begin
        int r0, e0, v0;
        logic [7:0] vars [5] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'hFF};
        int bad [5][4] = '{'{1, 0, FW, FH}, '{0, 1, FW, FH}, '{0, 0, FW - 1, FH},
                           '{0, 0, FW, FH + 1}, '{0, 0, 800, 480}};
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        idle_check("after reset");
        chk(!done && !err && !rd_valid && !pix_ready, "R1", "reset pulses low",
            {done, err, rd_valid, pix_ready}, 0);

        // R10 / R3: register read.
        acc_n = 0; r0 = rdv_n;
        @(negedge clk); rd_req = 1; rd_addr = 8'h00;
        @(negedge clk); rd_req = 0;
        while (rdv_n == r0) @(negedge clk);
        chk(rd_data == RD_GOOD, "R10", "read data", rd_data, RD_GOOD);
        repeat (3) @(negedge clk);
        chk(acc_n == 2, "R10", "read access count", acc_n, 2);
        chk_acc(0, 0, 0, 1, 16'h0000, "R10");
        chk(acc_len[1] == CYC_T && !acc_bad[1] && !acc_oe[1], "R3", "read access strobe",
            {acc_len[1], acc_bad[1], acc_oe[1]}, CYC_T);
        idle_check("after read");

        // R8: rejected windows.
        for (int i = 0; i < 5; i++) begin
            acc_n = 0; e0 = err_n;
            pulse_upd(bad[i][0], bad[i][1], bad[i][2], bad[i][3], 8'd1, 0);
            repeat (CYC_T + 4) @(negedge clk);
            chk(err_n == e0 + 1 && acc_n == 0 && !busy, "R8",
                $sformatf("reject window %0d", i), {err_n - e0, acc_n}, 1 << 32);
        end

        // R4..R7, R9: update sweep over variants, with and without stalls.
        for (int i = 0; i < 5; i++) run_update(vars[i], i[0], 0);

        // R11: simultaneous requests and requests while busy.
        r0 = rdv_n; v0 = done_n;
        run_update(8'd2, 1, 1);
        chk(rdv_n == r0, "R11", "read dropped on collision", rdv_n - r0, 0);
        chk(done_n == v0 + 1, "R11", "no second update", done_n - v0, 1);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule